// File: doc/BRIEF.md
# Dual-Source Random Byte Queue

This block gathers raw random bits from two independent entropy sources, packs them into bytes and then into 8-byte entries, and keeps up to `DEPTH` entries in a small first-in first-out queue. A consumer issues single-shot store requests. Each request that finds data removes one whole entry and returns it as one or two 32-bit write words, together with the pointer increment a store unit applies to its destination address and a byte count for the status word.

Two control inputs shape generation: an enable that stops all production while low, and a 2-bit source selector that picks source A alone, source B alone, or both sources interleaved. The consumer side looks the same in every source mode. A 2-bit divisor on each request decides how many bytes of the popped entry are real. The write word is always a full 32 bits, with any unused upper bytes forced to zero. The bytes that are not returned are lost.

Top module: `rng_byte_queue`

## Requirements
- R1: After reset, `resp_valid`, `wr_en`, `wr_two`, both write words, `ptr_inc` and `status_cnt` are all zero. The queue is empty, and any partial byte or entry is cleared.
- R2: With `src_sel` = 0, only source A supplies bits. One bit is taken per cycle while `src_a_vld` is high, and the first bit received becomes bit 0 of the byte. The first completed byte of an entry lands in bits 7:0 of `wr_word0`, and each later byte goes in the next higher byte lane (bytes 4 to 7 go to `wr_word1`).
- R3: With `src_sel` = 1, only source B supplies bits, and anything driven on source A has no effect on the entry.
- R4: With `src_sel` = 2, the completed bytes of an entry alternate between the sources. Entry bytes 0, 2, 4 and 6 come from source A, and bytes 1, 3, 5 and 7 come from source B.
- R5: The response to a request appears exactly one cycle after `req` is sampled, with `resp_valid` high for that one cycle. With divisor 0, the block raises `wr_en` and `wr_two`, returns all 8 bytes across `wr_word0` and `wr_word1`, and sets `ptr_inc` = `status_cnt` = 8.
- R6: With divisor 1, `wr_word0` carries entry bytes 0 to 3, `wr_two` is low, `wr_word1` is zero, and the count and increment are 4.
- R7: With divisor 2, `wr_word0` carries bytes 0 and 1 in its low half, its upper 16 bits are zero, and the count and increment are 2.
- R8: With divisor 3, `wr_word0` carries byte 0 in its low 8 bits, its upper 24 bits are zero, and the count and increment are 1.
- R9: A request made while the queue is empty gives `wr_en` low, both words zero, `ptr_inc` zero and `status_cnt` zero.
- R10: Every request that finds data removes one complete entry whatever the divisor, so the following request returns the next entry starting from its byte 0.
- R11: While `gen_en` is low, source bits are ignored and no entry is added to the queue.
- R12: The queue holds `DEPTH` entries and returns them in arrival order. While it is full, incoming source bits are dropped, so the bytes that arrive after a request frees an entry start a fresh byte and a fresh entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generation enable |
| src_sel | input | 2 | Source select: 0 = A, 1 = B, 2 = both interleaved, 3 = none |
| src_a_bit | input | 1 | Raw bit from source A |
| src_a_vld | input | 1 | Source A bit strobe |
| src_b_bit | input | 1 | Raw bit from source B |
| src_b_vld | input | 1 | Source B bit strobe |
| req | input | 1 | Single-cycle store request |
| divisor | input | 2 | Readout size for the request |
| resp_valid | output | 1 | Response strobe, one cycle after `req` |
| wr_en | output | 1 | The response carries a write |
| wr_two | output | 1 | Both write words are valid |
| wr_word0 | output | 32 | First write word |
| wr_word1 | output | 32 | Second write word |
| ptr_inc | output | 4 | Destination pointer increment |
| status_cnt | output | 4 | Byte count for the low status bits |

## Verification
The bench builds the block with the default depth of four entries. At that depth, filling the queue to the full state and holding it there takes only four entries of traffic. The same traffic carries both queue pointers through their wrap, so the tests for dropped bits while full and for in-order return after a wrap are short. Each source mode is paired with several divisors, with different data on the two sources, so a byte taken from the wrong source or placed in the wrong lane shows up at the write words.

// File: rtl/rng_byte_queue.sv
module rng_byte_queue #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gen_en,
  input  logic [1:0]  src_sel,
  input  logic        src_a_bit,
  input  logic        src_a_vld,
  input  logic        src_b_bit,
  input  logic        src_b_vld,
  input  logic        req,
  input  logic [1:0]  divisor,
  output logic        resp_valid,
  output logic        wr_en,
  output logic        wr_two,
  output logic [31:0] wr_word0,
  output logic [31:0] wr_word1,
  output logic [3:0]  ptr_inc,
  output logic [3:0]  status_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    sr_a, sr_b;
  logic [2:0]    bc_a, bc_b;
  logic          rdy_a, rdy_b;
  logic [63:0]   build;
  logic [2:0]    nbytes;
  logic          turn_b;
  logic [63:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] q_cnt;

  wire full   = (q_cnt == CW'(DEPTH));
  wire empty  = (q_cnt == '0);
  wire dual   = (src_sel == 2'd2);
  wire use_a  = gen_en && (src_sel == 2'd0 || dual);
  wire use_b  = gen_en && (src_sel == 2'd1 || dual);
  wire take_b = dual ? turn_b : (src_sel == 2'd1);
  wire take_ok   = take_b ? use_b : use_a;
  wire pick_rdy  = take_b ? rdy_b : rdy_a;
  wire [7:0] pick_byte = take_b ? sr_b : sr_a;
  wire accept  = !full && take_ok && pick_rdy;
  wire push    = accept && (nbytes == 3'd7);
  wire pop     = req && !empty;
  wire shift_a = use_a && !full && src_a_vld && !rdy_a;
  wire shift_b = use_b && !full && src_b_vld && !rdy_b;
  wire [63:0] head = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_a <= '0; bc_a <= '0; rdy_a <= 1'b0;
      sr_b <= '0; bc_b <= '0; rdy_b <= 1'b0;
    end else begin
      if (shift_a) begin
        sr_a[bc_a] <= src_a_bit;
        bc_a <= bc_a + 3'd1;
        if (bc_a == 3'd7) rdy_a <= 1'b1;
      end
      if (shift_b) begin
        sr_b[bc_b] <= src_b_bit;
        bc_b <= bc_b + 3'd1;
        if (bc_b == 3'd7) rdy_b <= 1'b1;
      end
      if (accept && !take_b) rdy_a <= 1'b0;
      if (accept && take_b)  rdy_b <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      build <= '0; nbytes <= '0; turn_b <= 1'b0;
    end else if (accept) begin
      build[{nbytes, 3'b000} +: 8] <= pick_byte;
      nbytes <= nbytes + 3'd1;
      if (dual) turn_b <= !turn_b;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {pick_byte, build[55:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; q_cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      q_cnt <= q_cnt + 1'b1;
      else if (pop && !push) q_cnt <= q_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0; wr_en <= 1'b0; wr_two <= 1'b0;
      wr_word0 <= '0; wr_word1 <= '0; ptr_inc <= '0; status_cnt <= '0;
    end else begin
      resp_valid <= req;
      wr_en    <= pop;
      wr_two   <= 1'b0;
      wr_word0 <= '0;
      wr_word1 <= '0;
      ptr_inc  <= '0;
      status_cnt <= '0;
      if (pop) begin
        case (divisor)
          2'd0: begin
            wr_word0 <= head[31:0]; wr_word1 <= head[63:32]; wr_two <= 1'b1;
            ptr_inc <= 4'd8; status_cnt <= 4'd8;
          end
          2'd1: begin
            wr_word0 <= head[31:0];
            ptr_inc <= 4'd4; status_cnt <= 4'd4;
          end
          2'd2: begin
            wr_word0 <= {16'h0, head[15:0]};
            ptr_inc <= 4'd2; status_cnt <= 4'd2;
          end
          default: begin
            wr_word0 <= {24'h0, head[7:0]};
            ptr_inc <= 4'd1; status_cnt <= 4'd1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rng_byte_queue_chk.sv
module rng_byte_queue_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req,
  input logic                       gen_en,
  input logic                       resp_valid,
  input logic                       wr_en,
  input logic                       wr_two,
  input logic [31:0]                wr_word0,
  input logic [31:0]                wr_word1,
  input logic [3:0]                 ptr_inc,
  input logic [3:0]                 status_cnt,
  input logic [$clog2(DEPTH+1)-1:0] q_cnt
);
  a_r5_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> resp_valid);

  a_r9_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && q_cnt == '0) |=> (!wr_en && status_cnt == 4'd0 && ptr_inc == 4'd0));

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  a_r11_disabled_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> q_cnt <= $past(q_cnt));

  a_r6_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && status_cnt != 4'd8) |-> (!wr_two && wr_word1 == 32'h0));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && status_cnt == 4'd2) |-> wr_word0[31:16] == 16'h0);

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && status_cnt == 4'd1) |-> wr_word0[31:8] == 24'h0);
endmodule

bind rng_byte_queue rng_byte_queue_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rng_byte_queue_test.sv
module rng_byte_queue_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic src_a_bit = 1'b0, src_a_vld = 1'b0, src_b_bit = 1'b0, src_b_vld = 1'b0;
  logic req = 1'b0;
  logic [1:0] divisor = 2'd0;
  logic resp_valid, wr_en, wr_two;
  logic [31:0] wr_word0, wr_word1;
  logic [3:0] ptr_inc, status_cnt;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rng_byte_queue #(.DEPTH(4)) uut (.*);

  // {src_sel, divisor}
  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0011, 4'b0100, 4'b0110,
                                     4'b1000, 4'b1001, 4'b0001, 4'b1011};

  function automatic logic [7:0] byte_a(int v, int k);
    return 8'((v * 53 + k * 29 + 7)) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] byte_b(int v, int k);
    return 8'((v * 71 + k * 13 + 3)) ^ 8'hC3;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [7:0] a, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      src_a_vld = 1'b1; src_a_bit = a[i];
      src_b_vld = 1'b1; src_b_bit = b[i];
    end
    @(negedge clk);
    src_a_vld = 1'b0; src_b_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(logic [1:0] sel, int v, output logic [63:0] ent);
    src_sel = sel;
    ent = '0;
    if (sel == 2'd2) begin
      for (int j = 0; j < 4; j++) begin
        step(byte_a(v, j), byte_b(v, j));
        ent[16*j +: 8] = byte_a(v, j);
        ent[16*j+8 +: 8] = byte_b(v, j);
      end
    end else begin
      for (int k = 0; k < 8; k++) begin
        step(byte_a(v, k), byte_b(v, k));
        ent[8*k +: 8] = (sel == 2'd0) ? byte_a(v, k) : byte_b(v, k);
      end
    end
  endtask

  task automatic request(logic [1:0] d);
    @(negedge clk);
    req = 1'b1; divisor = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_resp(string tag, logic [1:0] d, logic [63:0] ent);
    logic [31:0] w0, w1;
    logic [3:0] n;
    w1 = '0;
    case (d)
      2'd0: begin w0 = ent[31:0]; w1 = ent[63:32]; n = 4'd8; end
      2'd1: begin w0 = ent[31:0]; n = 4'd4; end
      2'd2: begin w0 = {16'h0, ent[15:0]}; n = 4'd2; end
      default: begin w0 = {24'h0, ent[7:0]}; n = 4'd1; end
    endcase
    check({tag, " ctl"}, {56'h0, resp_valid, wr_en, wr_two, 1'b0, n == 4'd8 ? 4'd8 : n},
          {56'h0, 1'b1, 1'b1, d == 2'd0, 1'b0, n});
    check({tag, " cnt"}, {56'h0, ptr_inc, status_cnt}, {56'h0, n, n});
    check({tag, " words"}, {wr_word1, wr_word0}, {w1, w0});
  endtask

  task automatic expect_empty(string tag);
    check({tag, " empty"}, {resp_valid, wr_en, wr_two, ptr_inc, status_cnt, wr_word1, wr_word0},
          {1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 64'h0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] ent;
    logic [63:0] q [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {resp_valid, wr_en, wr_two, ptr_inc, status_cnt, wr_word1, wr_word0}, '0);
    gen_en = 1'b1;
    request(2'd0);
    expect_empty("R1 R9 after reset");

    // R2 R3 R4 R5 R6 R7 R8: vector walk
    foreach (VEC[i]) begin
      fill(VEC[i][3:2], i, ent);
      request(VEC[i][1:0]);
      expect_resp($sformatf("R2 R3 R4 R5 R6 R7 R8 vec%0d", i), VEC[i][1:0], ent);
    end

    request(2'd1);
    expect_empty("R9 empty request");

    // R10: a short readout still consumes the whole entry
    fill(2'd0, 20, q[0]);
    fill(2'd0, 21, q[1]);
    request(2'd3);
    expect_resp("R10 first", 2'd3, q[0]);
    request(2'd0);
    expect_resp("R10 next entry", 2'd0, q[1]);

    // R11: generation disabled
    gen_en = 1'b0;
    fill(2'd0, 30, ent);
    fill(2'd2, 31, ent);
    request(2'd0);
    expect_empty("R11 disabled");
    gen_en = 1'b1;

    // R12: depth, order, drop while full
    for (int e = 0; e < 4; e++) fill(2'd0, 40 + e, q[e]);
    fill(2'd0, 50, ent);
    request(2'd0);
    expect_resp("R12 oldest", 2'd0, q[0]);
    fill(2'd0, 60, q[0]);
    for (int e = 1; e < 4; e++) begin
      request(2'd0);
      expect_resp($sformatf("R12 order%0d", e), 2'd0, q[e]);
    end
    request(2'd0);
    expect_resp("R12 after full drop", 2'd0, q[0]);
    request(2'd2);
    expect_empty("R12 drained");

    // R3: source B only with mixed divisor
    fill(2'd1, 70, ent);
    request(2'd2);
    expect_resp("R3 R7 source B", 2'd2, ent);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule